// File: doc/BRIEF.md
# Execute-Stage ALU Bypass and Interlock Control

This combinational control block works beside an in-order pipeline's interlock. It adds one forwarding path: an ALU result held in the execute stage can be routed back to the A operand of the instruction that is entering execute. Each cycle it decides whether operand A takes that bypassed value. It also produces a stall that no longer covers the hazards the bypass resolves.

Only register-register and register-immediate ALU results in execute can be forwarded. A load in execute still stalls a dependent rs read. So does a link-writing jump in execute, because neither has its value ready at the end of execute. Three kinds of hazard keep their plain interlock terms: the rt operand's match against execute, and both operands' matches against the memory and writeback stages. The block holds no state, so both outputs follow the inputs within the same cycle.

Top module: `exBypassCtl`

## Requirements
- R1: The execute-stage class code is 3 bits wide: 0 ALU, 1 ALU-immediate, 2 load, 3 store, 4 branch, 5 plain jump or register jump, 6 jump-and-link, 7 register jump-and-link. `aFromBypass` is 1 exactly when all of these hold: the class is 0 or 1, `exDest` is non-zero, `decRdA` is 1, and `decRs` equals `exDest`.
- R2: For classes 2 through 7, `aFromBypass` is 0 whatever the register fields and enables are.
- R3: The rs execute term stalls when `decRdA` is 1, `decRs` equals `exDest`, and either the class is 2 with a non-zero `exDest` or the class is 6 or 7. For classes 0 and 1, an rs match against execute does not stall.
- R4: The rt execute term stalls when `decRdB` is 1, `decRt` equals `exDest`, and `exWr` is 1, for every class.
- R5: The memory-stage terms stall when `memWr` is 1 and `memDest` matches `decRs` (with `decRdA`) or matches `decRt` (with `decRdB`).
- R6: The writeback-stage terms stall in the same way using `wbDest` and `wbWr`.
- R7: `stall` is the OR of the R3 to R6 terms. With both read enables at 0, `stall` and `aFromBypass` are both 0.
- R8: In any cycle where `aFromBypass` is 1, the rs execute term is 0. `stall` is then 1 only if some other term is active.
- R9: An ALU-immediate writing r1, followed by a decoded instruction that reads r1 as rs, gives `aFromBypass` = 1 and `stall` = 0 when no other hazard is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRs | input | REG_W | rs field of the instruction in decode |
| decRt | input | REG_W | rt field of the instruction in decode |
| decRdA | input | 1 | decode instruction reads rs |
| decRdB | input | 1 | decode instruction reads rt |
| exClass | input | 3 | opcode class of the instruction in execute |
| exDest | input | REG_W | destination register of the execute instruction |
| exWr | input | 1 | execute instruction writes a register |
| memDest | input | REG_W | destination register in the memory stage |
| memWr | input | 1 | memory-stage instruction writes a register |
| wbDest | input | REG_W | destination register in writeback |
| wbWr | input | 1 | writeback instruction writes a register |
| aFromBypass | output | 1 | operand A takes the execute ALU result |
| stall | output | 1 | hold decode and insert a bubble |

## Verification
The bench uses a 2-bit register index and sweeps every combination of the two source fields, both read enables, all eight classes, the three destinations and the three write enables. This covers matches and mismatches per stage, destination zero against non-zero, and each class against each operand. Each combination is checked against both outputs, so the sweep separates the forwarded rs case from the rt case, which still stalls, and separates load and link classes from ALU classes. Directed cases add the back-to-back dependent-add sequence, a bypass that coincides with a late-stage hazard, and a fully idle decode.

// File: rtl/exBypassPkg.sv
package exBypassPkg;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_ALUI   = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_JUMP   = 3'd5,
    CLS_JAL    = 3'd6,
    CLS_JALR   = 3'd7
  } opClassE;

  // Strobes from the class decoder to the compare datapath
  typedef struct packed {
    logic fwdOk;     // execute result can be bypassed to operand A
    logic rsHoldWr;  // execute write that an rs match must still wait for
  } exStrobesT;

endpackage

// File: rtl/exClassCtrl.sv
module exClassCtrl
  import exBypassPkg::*;
#(
  parameter int REG_W = 5
) (
  input  opClassE          exClass,
  input  logic [REG_W-1:0] exDest,
  output exStrobesT        strobes
);

  logic destLive;
  assign destLive = (exDest != '0);

  always_comb begin
    strobes = '0;
    unique case (exClass)
      CLS_ALU, CLS_ALUI: strobes.fwdOk    = destLive;
      CLS_LOAD:          strobes.rsHoldWr = destLive;
      CLS_JAL, CLS_JALR: strobes.rsHoldWr = 1'b1;
      default:           strobes = '0;
    endcase
  end

  // R2: only ALU classes may be marked forwardable
  always_comb
    if (strobes.fwdOk)
      a_r2_fwd_only_alu: assert (exClass == CLS_ALU || exClass == CLS_ALUI);

  // R3: forwarding and rs hold are exclusive per class
  always_comb
    if (strobes.fwdOk)
      a_r3_fwd_excl_hold: assert (!strobes.rsHoldWr);

endmodule

// File: rtl/hazMatchPath.sv
module hazMatchPath
  import exBypassPkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_LATE = 2
) (
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decRdA,
  input  logic             decRdB,
  input  logic [REG_W-1:0] exDest,
  input  logic             exWr,
  input  logic [REG_W-1:0] lateDest [NUM_LATE],
  input  logic             lateWr   [NUM_LATE],
  input  exStrobesT        strobes,
  output logic             selA,
  output logic             stall
);

  logic rsExHit, rsExStall, rtExStall;
  logic [NUM_LATE-1:0] rsLate, rtLate;

  assign rsExHit   = decRdA && (decRs == exDest);
  assign selA      = rsExHit && strobes.fwdOk;
  assign rsExStall = rsExHit && strobes.rsHoldWr;
  assign rtExStall = decRdB && (decRt == exDest) && exWr;

  for (genvar s = 0; s < NUM_LATE; s++) begin : gLate
    assign rsLate[s] = decRdA && lateWr[s] && (decRs == lateDest[s]);
    assign rtLate[s] = decRdB && lateWr[s] && (decRt == lateDest[s]);
  end

  assign stall = rsExStall || rtExStall || (|rsLate) || (|rtLate);

  // R8: a bypassed operand never also waits on execute
  always_comb
    if (selA)
      a_r8_bypass_excludes_rs_stall: assert (!rsExStall);

  // R7: no reads, no stall
  always_comb
    if (!decRdA && !decRdB)
      a_r7_idle_no_stall: assert (!stall && !selA);

endmodule

// File: rtl/exBypassCtl.sv
module exBypassCtl
  import exBypassPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decRdA,
  input  logic             decRdB,
  input  logic [2:0]       exClass,
  input  logic [REG_W-1:0] exDest,
  input  logic             exWr,
  input  logic [REG_W-1:0] memDest,
  input  logic             memWr,
  input  logic [REG_W-1:0] wbDest,
  input  logic             wbWr,
  output logic             aFromBypass,
  output logic             stall
);

  localparam int NUM_LATE = 2;

  exStrobesT        strobes;
  logic [REG_W-1:0] lateDest [NUM_LATE];
  logic             lateWr   [NUM_LATE];

  assign lateDest[0] = memDest;
  assign lateDest[1] = wbDest;
  assign lateWr[0]   = memWr;
  assign lateWr[1]   = wbWr;

  exClassCtrl #(.REG_W(REG_W)) uCtrl (
    .exClass (opClassE'(exClass)),
    .exDest  (exDest),
    .strobes (strobes)
  );

  hazMatchPath #(.REG_W(REG_W), .NUM_LATE(NUM_LATE)) uPath (
    .decRs    (decRs),
    .decRt    (decRt),
    .decRdA   (decRdA),
    .decRdB   (decRdB),
    .exDest   (exDest),
    .exWr     (exWr),
    .lateDest (lateDest),
    .lateWr   (lateWr),
    .strobes  (strobes),
    .selA     (aFromBypass),
    .stall    (stall)
  );

  // R1: a bypass needs a real rs match against execute
  always_comb
    if (aFromBypass)
      a_r1_bypass_needs_match: assert (decRdA && decRs == exDest && exDest != '0);

  // R3: a dependent load in execute always stalls
  always_comb
    if (exClass == 3'd2 && exDest != '0 && decRdA && decRs == exDest)
      a_r3_load_use_stalls: assert (stall && !aFromBypass);

endmodule

// File: tb/tb_exBypassCtl.sv
`timescale 1ns/100ps
module tb_exBypassCtl;

  localparam int RW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [RW-1:0] decRs, decRt, exDest, memDest, wbDest;
  logic decRdA, decRdB, exWr, memWr, wbWr;
  logic [2:0] exClass;
  logic aFromBypass, stall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  exBypassCtl #(.REG_W(RW)) dut (
    .decRs(decRs), .decRt(decRt), .decRdA(decRdA), .decRdB(decRdB),
    .exClass(exClass), .exDest(exDest), .exWr(exWr),
    .memDest(memDest), .memWr(memWr), .wbDest(wbDest), .wbWr(wbWr),
    .aFromBypass(aFromBypass), .stall(stall)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s: actual %b expected %b (rs=%0d rt=%0d rdA=%b rdB=%b cls=%0d ex=%0d/%b mem=%0d/%b wb=%0d/%b)",
                 req, act, exp, decRs, decRt, decRdA, decRdB, exClass,
                 exDest, exWr, memDest, memWr, wbDest, wbWr);
    end
  endtask

  task automatic drive(input logic [17:0] v);
    decRs   = v[1:0];   decRt   = v[3:2];
    decRdA  = v[4];     decRdB  = v[5];
    exClass = v[8:6];   exDest  = v[10:9];  exWr  = v[11];
    memDest = v[13:12]; memWr   = v[14];
    wbDest  = v[16:15]; wbWr    = v[17];
  endtask

  // Expected values derived from the requirements
  task automatic checkNow();
    logic isAlu, holdRs, expSel, t3, t4, t5, t6;
    isAlu  = (exClass == 3'd0) || (exClass == 3'd1);
    holdRs = (exClass == 3'd2 && exDest != 0) || exClass == 3'd6 || exClass == 3'd7;
    expSel = isAlu && exDest != 0 && decRdA && decRs == exDest;
    t3 = decRdA && decRs == exDest && holdRs;
    t4 = decRdB && decRt == exDest && exWr;
    t5 = memWr && ((decRdA && decRs == memDest) || (decRdB && decRt == memDest));
    t6 = wbWr && ((decRdA && decRs == wbDest) || (decRdB && decRt == wbDest));
    if (isAlu) chk("R1 aFromBypass", aFromBypass, expSel);
    else       chk("R2 aFromBypass", aFromBypass, 1'b0);
    chk("R3/R4/R5/R6 stall", stall, t3 || t4 || t5 || t6);
    if (!decRdA && !decRdB) chk("R7 idle stall", stall, 1'b0);
  endtask

  initial begin
    drive('0);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #0.5;
    // R7: idle decode, reset-like state
    drive('0); #1;
    chk("R7 idle bypass", aFromBypass, 1'b0);
    chk("R7 idle stall", stall, 1'b0);
    #0.5;
    // R9: r1 = r0 + imm in execute, decode reads r1 as rs
    #0.5;
    drive('0);
    exClass = 3'd1; exDest = 2'd1; exWr = 1'b1; decRs = 2'd1; decRdA = 1'b1;
    decRt = 2'd0; decRdB = 1'b0;
    #1;
    chk("R9 back-to-back bypass", aFromBypass, 1'b1);
    chk("R9 back-to-back no stall", stall, 1'b0);
    #0.5;
    // R8: bypass with a writeback hazard on rt still stalls via R6 only
    #0.5;
    decRt = 2'd3; decRdB = 1'b1; wbDest = 2'd3; wbWr = 1'b1;
    #1;
    chk("R8 bypass kept", aFromBypass, 1'b1);
    chk("R8 other term stalls", stall, 1'b1);
    #0.5;
    // R3: load in execute, same dependency
    #0.5;
    drive('0);
    exClass = 3'd2; exDest = 2'd1; exWr = 1'b1; decRs = 2'd1; decRdA = 1'b1;
    #1;
    chk("R3 load-use bypass", aFromBypass, 1'b0);
    chk("R3 load-use stall", stall, 1'b1);
    #0.5;
    // Exhaustive sweep, two vectors per clock
    for (int v = 0; v < (1 << 18); v++) begin
      #0.5;
      drive(v[17:0]);
      #1;
      checkNow();
      #0.5;
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule